// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves a programmed number of data words between one peripheral and system memory. The CPU does not take part in the moves. The CPU sets up a source address, a destination address, a word count and a mode through a small addressed register port, the same way it would program any I/O device. It then writes a start bit.

Two handshakes run the transfer. The first is with the peripheral: the peripheral raises a request line when it has a word to give or room to take one, and the controller answers with a one-cycle acknowledge for each word it moves. The second is with the CPU: the controller raises a bus request and drives the memory strobes only after the bus acknowledge comes back. In burst mode the controller keeps the bus until the count reaches zero. In cycle-steal mode it hands the bus back after every word. A one-cycle completion pulse tells the CPU the job has finished. The pulse is also held in a status bit that software clears.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: The register port selects a register with `reg_sel`: 0 = source address, 1 = destination address, 2 = remaining count, 3 = control, 4 = status. A write with `reg_wr` high loads the selected register at the clock edge. `reg_rdata` shows the selected register as a combinational read, zero-extended. Control bit 0 is start and reads back as 0, bit 1 is cycle-steal, and bit 2 is direction (1 = memory to peripheral). Status bit 0 is done and bit 1 is busy.
- R2: After a start with a nonzero count, `bus_req` rises on the next cycle. While `bus_ack` is low, no memory strobe and no `per_ack` is issued.
- R3: A word moves only in a cycle where `bus_req`, `bus_ack` and `per_req` are all high. In that cycle `per_ack` is high for exactly one cycle, exactly one memory strobe is high, and the number of acknowledges in a job equals the programmed count.
- R4: With direction 0, each word is written to memory (`mem_we`) at the destination address, and `mem_wdata` equals `per_din`. With direction 1, each word is read (`mem_re`) from the source address, and `per_dout` equals `mem_rdata`. The active address goes up by one after every word.
- R5: The count goes down by one and the active address goes up by one at the clock edge that ends the transfer cycle. During the k-th transfer (k counted from 0), register 2 reads count−k. After completion it reads 0, and the active address reads base+count.
- R6: In burst mode, `bus_req` stays high from its rise until the cycle after the last word, including cycles where `per_req` is low.
- R7: In cycle-steal mode, `bus_req` is low in the cycle after every word. Over a job it rises once per word.
- R8: `xfer_done` is a one-cycle pulse in the cycle after the last word. In that cycle `bus_req` is already low, and no `per_ack` follows it.
- R9: Status bit 0 is set by the completion pulse and stays set until software writes 1 to bit 0 of register 4.
- R10: A start with count 0 raises `xfer_done` in the cycle right after the start write, and `bus_req` never rises.
- R11: While busy, writes to registers 0 to 3, including a second start, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Selected register contents |
| per_req | input | 1 | Peripheral transfer request |
| per_ack | output | 1 | Peripheral transfer acknowledge, one per word |
| per_din | input | DW | Word from the peripheral |
| per_dout | output | DW | Word to the peripheral |
| bus_req | output | 1 | System bus request to the CPU |
| bus_ack | input | 1 | System bus grant from the CPU |
| xfer_done | output | 1 | Transfer-complete pulse |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench runs every combination of mode, direction and counts 0 to 5, each under two peripheral request patterns: held high, and toggling every cycle. The toggling pattern separates a controller that keeps the bus across gaps in burst mode from one that lets it go. The memory returns a value derived from the address and the peripheral supplies a value derived from the word index, so address steps, data paths and the count read during each transfer can all be checked. Separate runs hold off the bus grant, try to restart and rewrite registers while busy, and clear the done bit.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_RELEASE,
        ST_DONE
    } seq_state_e;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;

    localparam int CTRL_START = 0;
    localparam int CTRL_STEAL = 1;
    localparam int CTRL_RDMEM = 2;
    localparam int STAT_DONE  = 0;

endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
    import dma_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    input  logic          busy,
    input  logic          step,
    input  logic          cmpl,
    output logic [RW-1:0] reg_rdata,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          steal,
    output logic          rd_mem,
    output logic          cnt_zero,
    output logic          cnt_last
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic          steal;
        logic          rdmem;
        logic          done;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_wr && !busy) begin
            case (reg_sel)
                SEL_SRC:  r_d.src = reg_wdata[AW-1:0];
                SEL_DST:  r_d.dst = reg_wdata[AW-1:0];
                SEL_CNT:  r_d.cnt = reg_wdata[CW-1:0];
                SEL_CTRL: begin
                    r_d.steal = reg_wdata[CTRL_STEAL];
                    r_d.rdmem = reg_wdata[CTRL_RDMEM];
                end
                default: ;
            endcase
        end
        if (step) begin
            r_d.cnt = r_q.cnt - CW'(1);
            if (r_q.rdmem) r_d.src = r_q.src + AW'(1);
            else           r_d.dst = r_q.dst + AW'(1);
        end
        if (reg_wr && reg_sel == SEL_STAT && reg_wdata[STAT_DONE]) r_d.done = 1'b0;
        if (cmpl) r_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_SRC:  reg_rdata = RW'(r_q.src);
            SEL_DST:  reg_rdata = RW'(r_q.dst);
            SEL_CNT:  reg_rdata = RW'(r_q.cnt);
            SEL_CTRL: reg_rdata = RW'({r_q.rdmem, r_q.steal, 1'b0});
            SEL_STAT: reg_rdata = RW'({busy, r_q.done});
            default:  reg_rdata = '0;
        endcase
    end

    assign src_addr = r_q.src;
    assign dst_addr = r_q.dst;
    assign steal    = r_q.steal;
    assign rd_mem   = r_q.rdmem;
    assign cnt_zero = (r_q.cnt == '0);
    assign cnt_last = (r_q.cnt == CW'(1));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic per_req,
    input  logic bus_ack,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic steal,
    output logic busy,
    output logic step,
    output logic bus_req,
    output logic cmpl
);

    typedef struct packed {
        seq_state_e st;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        step = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) s_d.st = cnt_zero ? ST_DONE : ST_REQ;
            end
            ST_REQ: begin
                if (bus_ack) s_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (bus_ack && per_req) begin
                    step = 1'b1;
                    if (cnt_last)   s_d.st = ST_DONE;
                    else if (steal) s_d.st = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (per_req) s_d.st = ST_REQ;
            end
            ST_DONE:  s_d.st = ST_IDLE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.st <= ST_IDLE;
        else        s_q    <= s_d;
    end

    assign busy    = (s_q.st != ST_IDLE);
    assign bus_req = (s_q.st == ST_REQ) || (s_q.st == ST_XFER);
    assign cmpl    = (s_q.st == ST_DONE);

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dma_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8,
    localparam int RW = (AW > CW) ? AW : CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          per_req,
    output logic          per_ack,
    input  logic [DW-1:0] per_din,
    output logic [DW-1:0] per_dout,
    output logic          bus_req,
    input  logic          bus_ack,
    output logic          xfer_done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    logic          busy, step, cmpl, start;
    logic          cfg_steal, cfg_rdmem, cnt_zero, cnt_last;
    logic [AW-1:0] src_addr, dst_addr;

    assign start = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[CTRL_START];

    dma_xfer_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .busy     (busy),
        .step     (step),
        .cmpl     (cmpl),
        .reg_rdata(reg_rdata),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .steal    (cfg_steal),
        .rd_mem   (cfg_rdmem),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    dma_xfer_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .per_req (per_req),
        .bus_ack (bus_ack),
        .cnt_zero(cnt_zero),
        .cnt_last(cnt_last),
        .steal   (cfg_steal),
        .busy    (busy),
        .step    (step),
        .bus_req (bus_req),
        .cmpl    (cmpl)
    );

    assign per_ack   = step;
    assign xfer_done = cmpl;
    assign mem_addr  = cfg_rdmem ? src_addr : dst_addr;
    assign mem_we    = step && !cfg_rdmem;
    assign mem_re    = step && cfg_rdmem;
    assign mem_wdata = per_din;
    assign per_dout  = mem_rdata;

endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
module dma_xfer_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic per_req,
    input logic per_ack,
    input logic bus_req,
    input logic bus_ack,
    input logic xfer_done,
    input logic mem_we,
    input logic mem_re,
    input logic steal
);

    a_r3_ack_with_bus: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> (bus_req && bus_ack && per_req));

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));

    a_r2_no_strobe_unowned: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> (!mem_we && !mem_re && !per_ack));

    a_r6_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!steal && per_ack) |=> (bus_req || xfer_done));

    a_r7_steal_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (steal && per_ack) |=> !bus_req);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    a_r8_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!bus_req && !per_ack));

endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .per_req  (per_req),
    .per_ack  (per_ack),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .xfer_done(xfer_done),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .steal    (cfg_steal)
);

// File: tb/dma_xfer_ctrl_tb_top.sv
module dma_xfer_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd2;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic [15:0] per_din;
    logic [15:0] per_dout;
    logic        bus_req;
    logic        bus_ack = 1'b0;
    logic        xfer_done;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int checks = 0;
    int errors = 0;

    // run context
    int          k = 0;
    int          run_cnt = 0;
    int          req_rises = 0;
    int          done_pulses = 0;
    bit          mon_on = 0, req_on = 0, gap = 0, hold_ack = 0;
    bit          m_steal = 0, m_rd = 0;
    logic [15:0] src_base = '0, dst_base = '0;
    logic        prev_req = 0, prev_dack = 0;
    int          cyc = 0;

    always #10 clk = ~clk;

    assign per_din   = 16'h1000 + 16'(k);
    assign mem_rdata = mem_addr ^ 16'hA5A5;

    dma_xfer_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_ack(per_ack), .per_din(per_din), .per_dout(per_dout),
        .bus_req(bus_req), .bus_ack(bus_ack), .xfer_done(xfer_done),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // CPU grant and peripheral request models, driven after the edge
    always @(posedge clk) begin
        #1;
        cyc++;
        bus_ack <= bus_req && !hold_ack;
        per_req <= req_on && (!gap || cyc[0]);
    end

    // monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (mon_on) begin
            if (bus_req && !prev_req) req_rises++;
            if (prev_dack) begin
                if (k < run_cnt) begin
                    if (m_steal) chk(!bus_req, "R7 bus_req after word", bus_req, 0);
                    else         chk(bus_req,  "R6 bus_req held", bus_req, 1);
                end else begin
                    chk(!bus_req, "R8 bus_req after last word", bus_req, 0);
                end
            end
            if ((mem_we || mem_re) && !per_ack) chk(0, "R3 strobe without ack", 1, 0);
            if (per_ack) begin
                chk(k < run_cnt, "R8 ack beyond count", k, run_cnt);
                if (m_rd) begin
                    chk(mem_re && !mem_we, "R4 read strobe", {mem_re, mem_we}, 2);
                    chk(mem_addr == src_base + 16'(k), "R4 read address", mem_addr, src_base + 16'(k));
                    chk(per_dout == ((src_base + 16'(k)) ^ 16'hA5A5), "R4 per_dout", per_dout,
                        (src_base + 16'(k)) ^ 16'hA5A5);
                end else begin
                    chk(mem_we && !mem_re, "R4 write strobe", {mem_re, mem_we}, 1);
                    chk(mem_addr == dst_base + 16'(k), "R4 write address", mem_addr, dst_base + 16'(k));
                    chk(mem_wdata == 16'h1000 + 16'(k), "R4 mem_wdata", mem_wdata, 16'h1000 + 16'(k));
                end
                if (reg_sel == 3'd2 && !reg_wr)
                    chk(reg_rdata == 16'(run_cnt - k), "R5 count during word", reg_rdata, run_cnt - k);
                k++;
            end
            if (xfer_done) begin
                done_pulses++;
                chk(!bus_req && !per_ack, "R8 quiet at done", {bus_req, per_ack}, 0);
                chk(k == run_cnt, "R3 words moved", k, run_cnt);
            end
            prev_req  = bus_req;
            prev_dack = per_ack;
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(posedge clk); #2;
        reg_wr = 1'b0; reg_sel = 3'd2;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [15:0] val);
        @(posedge clk); #2;
        reg_sel = sel;
        @(negedge clk);
        val = reg_rdata;
        @(posedge clk); #2;
        reg_sel = 3'd2;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && done_pulses == 0; i++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic run_case(input bit steal, input bit rdm, input int cnt, input bit g,
                            input bit hold, input bit poke);
        logic [15:0] v;
        k = 0; run_cnt = cnt; req_rises = 0; done_pulses = 0;
        prev_req = 0; prev_dack = 0;
        m_steal = steal; m_rd = rdm; gap = g;
        src_base = 16'h0100 * 16'(cnt + 1);
        dst_base = 16'h4000 + 16'h0010 * 16'(cnt);
        wr(3'd0, src_base);
        wr(3'd1, dst_base);
        wr(3'd2, 16'(cnt));
        hold_ack = hold;
        req_on = 1; mon_on = 1;
        wr(3'd3, {13'd0, rdm, steal, 1'b1});
        if (cnt == 0) chk(xfer_done == 1'b1, "R10 immediate done", xfer_done, 1);
        if (hold) begin
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                chk(bus_req && !per_ack && !mem_we && !mem_re, "R2 wait for grant",
                    {bus_req, per_ack, mem_we, mem_re}, 8);
            end
            hold_ack = 0;
        end
        if (poke) begin
            repeat (2) @(posedge clk);
            wr(3'd2, 16'd9);
            wr(3'd0, 16'hBEEF);
            wr(3'd3, 16'h0007);
        end
        wait_done();
        mon_on = 0; req_on = 0;
        chk(done_pulses == 1, "R8 one pulse", done_pulses, 1);
        chk(k == cnt, "R3 ack count", k, cnt);
        if (cnt == 0)      chk(req_rises == 0, "R10 no bus request", req_rises, 0);
        else if (steal)    chk(req_rises == cnt, "R7 request per word", req_rises, cnt);
        else               chk(req_rises == 1, "R6 single request", req_rises, 1);
        rd(3'd2, v);
        chk(v == 16'd0, "R5 final count", v, 0);
        if (rdm) begin
            rd(3'd0, v);
            chk(v == src_base + 16'(cnt), "R5 final source", v, src_base + 16'(cnt));
        end else begin
            rd(3'd1, v);
            chk(v == dst_base + 16'(cnt), "R5 final destination", v, dst_base + 16'(cnt));
        end
        if (poke) begin
            rd(3'd3, v);
            chk(v == {13'd0, rdm, steal, 1'b0}, "R11 control unchanged", v, {rdm, steal, 1'b0});
        end
        rd(3'd4, v);
        chk(v == 16'd1, "R9 done sticky", v, 1);
        wr(3'd4, 16'd1);
        rd(3'd4, v);
        chk(v == 16'd0, "R9 done cleared", v, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !per_ack && !xfer_done && !mem_we && !mem_re, "R8 reset outputs",
            {bus_req, per_ack, xfer_done, mem_we, mem_re}, 0);
        rd(3'd4, v);
        chk(v == 16'd0, "R9 reset status", v, 0);

        // R1: register load and readback without starting
        wr(3'd0, 16'h1234); rd(3'd0, v); chk(v == 16'h1234, "R1 source", v, 16'h1234);
        wr(3'd1, 16'hABCD); rd(3'd1, v); chk(v == 16'hABCD, "R1 destination", v, 16'hABCD);
        wr(3'd2, 16'h00C3); rd(3'd2, v); chk(v == 16'h00C3, "R1 count", v, 16'h00C3);
        wr(3'd3, 16'h0006); rd(3'd3, v); chk(v == 16'h0006, "R1 control", v, 6);
        rd(3'd4, v); chk(v == 16'd0, "R1 idle status", v, 0);

        // sweep: mode x direction x count x request pattern
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < 6; c++)
                    for (int g = 0; g < 2; g++)
                        run_case(s[0], d[0], c, g[0], 1'b0, 1'b0);

        // R2: grant held off; R11: writes and restart while busy
        run_case(1'b0, 1'b0, 2, 1'b0, 1'b1, 1'b0);
        run_case(1'b1, 1'b1, 3, 1'b0, 1'b1, 1'b0);
        run_case(1'b0, 1'b0, 4, 1'b1, 1'b0, 1'b1);
        run_case(1'b1, 1'b0, 4, 1'b1, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule